// File: doc/BRIEF.md
# Dual Saturating Multiply-Accumulate Unit

This block is the arithmetic core of a signal-processing engine. It holds two 40-bit accumulators and runs one operation per clock on one of them. The operation can load or add a 16-bit operand, add the product of a 17x17 multiplier, add or subtract the other accumulator, or negate. The selected accumulator is both the first source and the destination. Before it reaches the 40-bit adder, every addend passes through a barrel shifter that can shift up to 16 places left or right.

Each result goes through a saturation stage with three modes, chosen per operation. Each accumulator has two flags of its own: a sticky saturation flag and an overflow flag that reflects its most recent write. Operand fetch and instruction decode are done outside the block.

Operations arrive on a valid/ready stream. The block never applies back-pressure: `op_ready` goes high on the first clock edge after reset is released and stays high. An operation is taken on every edge where `op_valid` and `op_ready` are both high. The `sat_clr` input is not part of the stream and acts on its own.

Top module: `dual_acc_mac`

## Requirements
- R1: While reset is low and after it is released, both accumulators and all four flags read zero. `op_ready` is low during reset and is high from the first rising edge after release.
- R2: An operation taken at a rising edge changes only the accumulator chosen by `acc_sel` (0 = A, 1 = B), and the new value is visible after that same edge. Opcode 1 (load) writes the sign-extended 16-bit `opa`, after the shift.
- R3: Opcode 2 adds, and opcode 3 subtracts, the sign-extended and shifted `opa` to or from the selected accumulator.
- R4: Opcode 4 adds the shifted product of `opa` and `opb`. Each operand is extended into a 17th bit, by sign when `mul_signed` is 1 and by zero when it is 0. The 33-bit product is doubled when `mul_frac` is 1 and kept as an integer when it is 0, then sign-extended to 40 bits.
- R5: `shift_amt` is a 6-bit two's-complement value. A positive value shifts the addend left, and a negative value shifts it arithmetically right. A magnitude above 16 acts as 16, and the bits shifted out past bit 39 are lost.
- R6: Opcode 5 adds, and opcode 6 subtracts, the shifted value of the other accumulator. Opcode 7 replaces the selected accumulator with its negation. `opa` and `opb` have no effect on any of the three.
- R7: With `sat_mode` 0 (and with 3, which acts the same), a result outside the 40-bit signed range becomes 0x7FFFFFFFFF or 0x8000000000 and sets the saturation flag.
- R8: With `sat_mode` 1, a result above 0x007FFFFFFF becomes 0x007FFFFFFF and a result below 0xFF80000000 becomes 0xFF80000000, and either case sets the saturation flag. 0xFF80000000 itself passes unchanged.
- R9: With `sat_mode` 2, the result wraps to 40 bits, and the saturation flag is set when the true result leaves the 40-bit range.
- R10: Saturation flags stay set until a cycle with `sat_clr` high. A saturation in that same cycle keeps the flag set. Each flag belongs to one accumulator.
- R11: An accumulator's overflow flag shows, for its latest write, whether the true result was outside the 32-bit signed range. Writes to the other accumulator leave it unchanged.
- R12: Opcode 0, and any cycle with `op_valid` low, leaves both accumulators and both overflow flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | An operation is offered |
| op_ready | output | 1 | Operation accepted when high together with op_valid |
| op_code | input | 3 | 0 nop, 1 load, 2 add, 3 sub, 4 mac, 5 add other, 6 sub other, 7 negate |
| acc_sel | input | 1 | Selected accumulator: 0 = A, 1 = B |
| opa | input | 16 | Data operand and first multiplier operand |
| opb | input | 16 | Second multiplier operand |
| mul_signed | input | 1 | 1 = signed multiply operands |
| mul_frac | input | 1 | 1 = fractional (doubled) product |
| shift_amt | input | 6 | Signed addend shift, positive means left |
| sat_mode | input | 2 | 0 wide saturate, 1 narrow saturate, 2 wrap with detect |
| sat_clr | input | 1 | Clears both saturation flags |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |
| sat_a | output | 1 | Sticky saturation flag of A |
| sat_b | output | 1 | Sticky saturation flag of B |
| ovf_a | output | 1 | Overflow flag of A |
| ovf_b | output | 1 | Overflow flag of B |

## Verification
Clearing the saturation flags and raising a new saturation event can both happen in the same cycle. The bench provokes this by driving `sat_clr` high in the same cycle as an add that pushes A past its 40-bit limit. It then expects `sat_a` to stay high after that edge, and to drop only on a later cycle that has the clear and no saturation. A second pairing is an accumulator that reads its own old value and the other accumulator while being rewritten. This is judged by checking the sum after each edge and by checking that the unselected accumulator holds its value.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_LOAD = 3'd1,
    OP_ADD  = 3'd2,
    OP_SUB  = 3'd3,
    OP_MAC  = 3'd4,
    OP_ADDX = 3'd5,
    OP_SUBX = 3'd6,
    OP_NEG  = 3'd7
  } dacc_op_e;

  typedef enum logic [1:0] {
    SAT_WIDE   = 2'd0,
    SAT_NARROW = 2'd1,
    SAT_WRAP   = 2'd2,
    SAT_ALT    = 2'd3
  } dacc_sat_e;
endpackage

// File: rtl/dacc_mul.sv
module dacc_mul #(
  parameter int DW = 16
) (
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  input  logic            sgn_i,
  input  logic            frac_i,
  output logic [2*DW+1:0] prod_o
);
  localparam int EW = DW + 1;
  localparam int PW = 2 * DW + 1;

  logic signed [EW-1:0]   ea, eb;
  logic signed [2*EW-1:0] full;
  logic        [PW-1:0]   p;

  // extend each operand into a 17th bit: sign or zero
  assign ea   = {sgn_i & a_i[DW-1], a_i};
  assign eb   = {sgn_i & b_i[DW-1], b_i};
  assign full = ea * eb;
  assign p    = full[PW-1:0];
  assign prod_o = frac_i ? {p, 1'b0} : {p[PW-1], p};
endmodule

// File: rtl/dacc_shift.sv
module dacc_shift #(
  parameter int W   = 40,
  parameter int SW  = 6,
  parameter int MAX = 16
) (
  input  logic [W-1:0]  din_i,
  input  logic [SW-1:0] amt_i,
  output logic [W-1:0]  dout_o
);
  logic [SW-1:0] mag_raw, mag;

  assign mag_raw = amt_i[SW-1] ? (~amt_i + 1'b1) : amt_i;
  assign mag     = (mag_raw > SW'(MAX)) ? SW'(MAX) : mag_raw;
  assign dout_o  = amt_i[SW-1] ? W'($signed(din_i) >>> mag) : (din_i << mag);
endmodule

// File: rtl/dacc_sat.sv
module dacc_sat
  import dacc_pkg::*;
#(
  parameter int W  = 40,
  parameter int NW = 32
) (
  input  logic [W:0]   sum_i,
  input  dacc_sat_e    mode_i,
  output logic [W-1:0] res_o,
  output logic         sat_evt_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] WMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] WMIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] NMAX = {{(W-NW+1){1'b0}}, {(NW-1){1'b1}}};
  localparam logic [W-1:0] NMIN = {{(W-NW+1){1'b1}}, {(NW-1){1'b0}}};

  logic wide_ovf;

  assign wide_ovf = sum_i[W] ^ sum_i[W-1];
  assign ovf_o    = !((&sum_i[W:NW-1]) || !(|sum_i[W:NW-1]));

  always_comb begin
    res_o     = sum_i[W-1:0];
    sat_evt_o = 1'b0;
    case (mode_i)
      SAT_NARROW: begin
        sat_evt_o = ovf_o;
        if (ovf_o) res_o = sum_i[W] ? NMIN : NMAX;
      end
      SAT_WRAP: begin
        sat_evt_o = wide_ovf;
      end
      default: begin
        sat_evt_o = wide_ovf;
        if (wide_ovf) res_o = sum_i[W] ? WMIN : WMAX;
      end
    endcase
  end
endmodule

// File: rtl/dual_acc_mac.sv
module dual_acc_mac
  import dacc_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ACC_W     = 40,
  parameter int NARROW_W  = 32,
  parameter int SHIFT_W   = 6,
  parameter int MAX_SHIFT = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  output logic               op_ready,
  input  logic [2:0]         op_code,
  input  logic               acc_sel,
  input  logic [DATA_W-1:0]  opa,
  input  logic [DATA_W-1:0]  opb,
  input  logic               mul_signed,
  input  logic               mul_frac,
  input  logic [SHIFT_W-1:0] shift_amt,
  input  logic [1:0]         sat_mode,
  input  logic               sat_clr,
  output logic [ACC_W-1:0]   acc_a,
  output logic [ACC_W-1:0]   acc_b,
  output logic               sat_a,
  output logic               sat_b,
  output logic               ovf_a,
  output logic               ovf_b
);
  localparam int PRW = 2 * DATA_W + 2;
  localparam int NACC = 2;

  dacc_op_e  op;
  dacc_sat_e mode;
  logic      ready_q, fire;

  logic [NACC-1:0][ACC_W-1:0] acc_bus;
  logic [NACC-1:0]            sat_bus, ovf_bus;

  logic [ACC_W-1:0] own, other, opa_ext, prod_ext, pre_shift, shifted;
  logic [ACC_W-1:0] base, addend, res;
  logic [ACC_W:0]   sum;
  logic             do_sub, sat_evt, ovf;
  logic [PRW-1:0]   prod;

  assign op   = dacc_op_e'(op_code);
  assign mode = dacc_sat_e'(sat_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign op_ready = ready_q;
  assign fire     = op_valid && ready_q;

  assign own   = acc_bus[acc_sel];
  assign other = acc_bus[!acc_sel];

  dacc_mul #(.DW(DATA_W)) mul_i (
    .a_i(opa), .b_i(opb), .sgn_i(mul_signed), .frac_i(mul_frac), .prod_o(prod)
  );

  assign opa_ext  = {{(ACC_W-DATA_W){opa[DATA_W-1]}}, opa};
  assign prod_ext = {{(ACC_W-PRW){prod[PRW-1]}}, prod};

  always_comb begin
    case (op)
      OP_MAC:          pre_shift = prod_ext;
      OP_ADDX, OP_SUBX: pre_shift = other;
      default:         pre_shift = opa_ext;
    endcase
  end

  dacc_shift #(.W(ACC_W), .SW(SHIFT_W), .MAX(MAX_SHIFT)) shift_i (
    .din_i(pre_shift), .amt_i(shift_amt), .dout_o(shifted)
  );

  always_comb begin
    base   = own;
    addend = shifted;
    do_sub = 1'b0;
    case (op)
      OP_NOP:  addend = '0;
      OP_LOAD: base   = '0;
      OP_SUB, OP_SUBX: do_sub = 1'b1;
      OP_NEG: begin
        base   = '0;
        addend = own;
        do_sub = 1'b1;
      end
      default: ;
    endcase
  end

  assign sum = do_sub ? ({base[ACC_W-1], base} - {addend[ACC_W-1], addend})
                      : ({base[ACC_W-1], base} + {addend[ACC_W-1], addend});

  dacc_sat #(.W(ACC_W), .NW(NARROW_W)) sat_i (
    .sum_i(sum), .mode_i(mode), .res_o(res), .sat_evt_o(sat_evt), .ovf_o(ovf)
  );

  for (genvar g = 0; g < NACC; g++) begin : g_acc
    logic             we;
    logic [ACC_W-1:0] acc_q;
    logic             sat_q, ovf_q;

    assign we = fire && (op != OP_NOP) && (acc_sel == 1'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q <= '0;
        sat_q <= 1'b0;
        ovf_q <= 1'b0;
      end else begin
        if (we) begin
          acc_q <= res;
          ovf_q <= ovf;
        end
        sat_q <= (sat_q && !sat_clr) || (we && sat_evt);
      end
    end

    assign acc_bus[g] = acc_q;
    assign sat_bus[g] = sat_q;
    assign ovf_bus[g] = ovf_q;
  end

  assign acc_a = acc_bus[0];
  assign acc_b = acc_bus[1];
  assign sat_a = sat_bus[0];
  assign sat_b = sat_bus[1];
  assign ovf_a = ovf_bus[0];
  assign ovf_b = ovf_bus[1];

  assert_ready_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    op_ready |=> op_ready);

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && op_ready) |=> ($stable(acc_a) && $stable(acc_b)));

  assert_unselected_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && acc_sel) |=> $stable(acc_a));

  assert_narrow_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && !acc_sel && op_code != 3'd0 && sat_mode == 2'd1)
      |=> ((&acc_a[ACC_W-1:NARROW_W-1]) || !(|acc_a[ACC_W-1:NARROW_W-1])));

  assert_sat_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_a && !sat_clr) |=> sat_a);

  assert_ovf_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && op_ready && !acc_sel) |=> $stable(ovf_a));
endmodule

// File: tb/dual_acc_mac_tb_top.sv
`timescale 1ns/1ps
module dual_acc_mac_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [2:0]  op_code = '0;
  logic        acc_sel = 1'b0;
  logic [15:0] opa = '0, opb = '0;
  logic        mul_signed = 1'b0, mul_frac = 1'b0;
  logic [5:0]  shift_amt = '0;
  logic [1:0]  sat_mode = '0;
  logic        sat_clr = 1'b0;
  logic [39:0] acc_a, acc_b;
  logic        sat_a, sat_b, ovf_a, ovf_b;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  dual_acc_mac dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .acc_sel(acc_sel), .opa(opa), .opb(opb),
    .mul_signed(mul_signed), .mul_frac(mul_frac), .shift_amt(shift_amt),
    .sat_mode(sat_mode), .sat_clr(sat_clr), .acc_a(acc_a), .acc_b(acc_b),
    .sat_a(sat_a), .sat_b(sat_b), .ovf_a(ovf_a), .ovf_b(ovf_b)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic        sel;
    logic [15:0] a;
    logic [15:0] b;
    logic        sgn;
    logic        frac;
    logic [5:0]  sh;
    logic [39:0] ea;
    logic [39:0] eb;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{3'd1, 1'b0, 16'h0123, 16'h0000, 1'b0, 1'b0, 6'd0,  40'h0000000123, 40'h0000000000}, // R2 load
    '{3'd1, 1'b1, 16'hFFFE, 16'h0000, 1'b0, 1'b0, 6'd0,  40'h0000000123, 40'hFFFFFFFFFE}, // R2 sign ext
    '{3'd2, 1'b0, 16'h0010, 16'h0000, 1'b0, 1'b0, 6'd0,  40'h0000000133, 40'hFFFFFFFFFE}, // R3 add
    '{3'd3, 1'b0, 16'h0033, 16'h0000, 1'b0, 1'b0, 6'd0,  40'h0000000100, 40'hFFFFFFFFFE}, // R3 sub
    '{3'd4, 1'b1, 16'hFFFF, 16'h0003, 1'b1, 1'b0, 6'd0,  40'h0000000100, 40'hFFFFFFFFFB}, // R4 signed
    '{3'd4, 1'b0, 16'hFFFF, 16'h0002, 1'b0, 1'b0, 6'd0,  40'h00000200FE, 40'hFFFFFFFFFB}, // R4 unsigned
    '{3'd4, 1'b0, 16'h4000, 16'h4000, 1'b1, 1'b1, 6'd0,  40'h00200200FE, 40'hFFFFFFFFFB}, // R4 frac
    '{3'd1, 1'b1, 16'h0001, 16'h0000, 1'b0, 1'b0, 6'd16, 40'h00200200FE, 40'h0000010000}, // R5 left 16
    '{3'd1, 1'b0, 16'h8000, 16'h0000, 1'b0, 1'b0, 6'h3C, 40'hFFFFFFF800, 40'h0000010000}, // R5 right 4
    '{3'd5, 1'b0, 16'h5555, 16'h0000, 1'b0, 1'b0, 6'd0,  40'h000000F800, 40'h0000010000}, // R6 add other
    '{3'd6, 1'b1, 16'h1111, 16'h0000, 1'b0, 1'b0, 6'd0,  40'h000000F800, 40'h0000000800}, // R6 sub other
    '{3'd7, 1'b0, 16'h1234, 16'h9999, 1'b0, 1'b0, 6'd0,  40'hFFFFFF0800, 40'h0000000800}, // R6 negate
    '{3'd5, 1'b1, 16'h0000, 16'h0000, 1'b0, 1'b0, 6'h38, 40'hFFFFFF0800, 40'h0000000708}, // R5 R6 shifted other
    '{3'd0, 1'b0, 16'h7777, 16'h7777, 1'b1, 1'b1, 6'd3,  40'hFFFFFF0800, 40'h0000000708}, // R12 nop
    '{3'd4, 1'b1, 16'h8000, 16'h8000, 1'b1, 1'b0, 6'd1,  40'hFFFFFF0800, 40'h0080000708}  // R4 R5 min*min
  };

  task automatic chk40(input string req, input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] o, input logic s, input logic [15:0] a,
                       input logic [15:0] b, input logic sg, input logic fr,
                       input logic [5:0] sh, input logic [1:0] md, input logic clr,
                       input logic vld);
    op_code = o; acc_sel = s; opa = a; opb = b; mul_signed = sg; mul_frac = fr;
    shift_amt = sh; sat_mode = md; sat_clr = clr; op_valid = vld;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    sat_clr  = 1'b0;
  endtask

  task automatic clear_flags();
    issue(3'd0, 1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 6'd0, 2'd0, 1'b1, 1'b0);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R12 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk40("R1 reset acc_a", acc_a, 40'h0);
    chk1("R1 ready low in reset", op_ready, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk1("R1 ready after release", op_ready, 1'b1);
    chk40("R1 acc_b", acc_b, 40'h0);
    chk1("R1 flags", sat_a | sat_b | ovf_a | ovf_b, 1'b0);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i].op, VEC[i].sel, VEC[i].a, VEC[i].b, VEC[i].sgn, VEC[i].frac,
            VEC[i].sh, 2'd0, 1'b0, 1'b1);
      chk40($sformatf("R2 vector %0d acc_a", i), acc_a, VEC[i].ea);
      chk40($sformatf("R2 vector %0d acc_b", i), acc_b, VEC[i].eb);
    end

    // R5 magnitude limit
    issue(3'd1, 1'b0, 16'h0001, 16'h0, 1'b0, 1'b0, 6'd20, 2'd0, 1'b0, 1'b1);
    chk40("R5 left limit", acc_a, 40'h0000010000);
    issue(3'd1, 1'b0, 16'h8000, 16'h0, 1'b0, 1'b0, 6'h2C, 2'd0, 1'b0, 1'b1);
    chk40("R5 right limit", acc_a, 40'hFFFFFFFFFF);

    // R12 no valid
    issue(3'd1, 1'b0, 16'h1234, 16'h0, 1'b0, 1'b0, 6'd0, 2'd0, 1'b0, 1'b0);
    chk40("R12 idle acc_a", acc_a, 40'hFFFFFFFFFF);

    // R7 positive wide saturation
    issue(3'd1, 1'b1, 16'h4000, 16'h0, 1'b0, 1'b0, 6'd16, 2'd0, 1'b0, 1'b1);
    issue(3'd1, 1'b0, 16'h4000, 16'h0, 1'b0, 1'b0, 6'd16, 2'd0, 1'b0, 1'b1);
    issue(3'd5, 1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 6'd8, 2'd0, 1'b0, 1'b1);
    chk40("R7 below limit", acc_a, 40'h4040000000);
    chk1("R11 ovf beyond 32", ovf_a, 1'b1);
    chk1("R7 no sat yet", sat_a, 1'b0);
    issue(3'd5, 1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 6'd8, 2'd0, 1'b0, 1'b1);
    chk40("R7 clamp max", acc_a, 40'h7FFFFFFFFF);
    chk1("R7 sat_a", sat_a, 1'b1);
    chk1("R10 sat_b separate", sat_b, 1'b0);
    chk40("R2 acc_b held", acc_b, 40'h0040000000);

    // R10 sticky, clear and set together
    issue(3'd0, 1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 6'd0, 2'd0, 1'b0, 1'b1);
    chk1("R10 sticky", sat_a, 1'b1);
    issue(3'd5, 1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 6'd8, 2'd0, 1'b1, 1'b1);
    chk1("R10 set beats clear", sat_a, 1'b1);
    clear_flags();
    chk1("R10 cleared", sat_a, 1'b0);

    // R7 negative
    issue(3'd1, 1'b0, 16'hC000, 16'h0, 1'b0, 1'b0, 6'd16, 2'd0, 1'b0, 1'b1);
    issue(3'd6, 1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 6'd8, 2'd0, 1'b0, 1'b1);
    chk40("R7 negative below limit", acc_a, 40'hBFC0000000);
    issue(3'd6, 1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 6'd8, 2'd0, 1'b0, 1'b1);
    chk40("R7 clamp min", acc_a, 40'h8000000000);
    chk1("R7 sat_a neg", sat_a, 1'b1);
    clear_flags();

    // R8 narrow
    issue(3'd1, 1'b0, 16'h4000, 16'h0, 1'b0, 1'b0, 6'd16, 2'd1, 1'b0, 1'b1);
    issue(3'd5, 1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 6'd0, 2'd1, 1'b0, 1'b1);
    chk40("R8 clamp narrow max", acc_a, 40'h007FFFFFFF);
    chk1("R8 sat", sat_a, 1'b1);
    clear_flags();
    issue(3'd1, 1'b0, 16'hC000, 16'h0, 1'b0, 1'b0, 6'd16, 2'd1, 1'b0, 1'b1);
    issue(3'd6, 1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 6'd0, 2'd1, 1'b0, 1'b1);
    chk40("R8 exact min", acc_a, 40'hFF80000000);
    chk1("R8 no sat at min", sat_a, 1'b0);
    chk1("R11 no ovf at min", ovf_a, 1'b0);
    issue(3'd3, 1'b0, 16'h0001, 16'h0, 1'b0, 1'b0, 6'd0, 2'd1, 1'b0, 1'b1);
    chk40("R8 clamp narrow min", acc_a, 40'hFF80000000);
    chk1("R8 sat below min", sat_a, 1'b1);
    chk1("R11 ovf below min", ovf_a, 1'b1);
    clear_flags();

    // R9 wrap
    issue(3'd1, 1'b0, 16'h4000, 16'h0, 1'b0, 1'b0, 6'd16, 2'd2, 1'b0, 1'b1);
    issue(3'd5, 1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 6'd8, 2'd2, 1'b0, 1'b1);
    issue(3'd5, 1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 6'd8, 2'd2, 1'b0, 1'b1);
    chk40("R9 wrapped", acc_a, 40'h8040000000);
    chk1("R9 sat detect", sat_a, 1'b1);

    // R11 ovf follows latest write
    issue(3'd1, 1'b0, 16'h0001, 16'h0, 1'b0, 1'b0, 6'd0, 2'd2, 1'b0, 1'b1);
    chk1("R11 ovf follows", ovf_a, 1'b0);
    chk1("R10 sat kept", sat_a, 1'b1);
    chk1("R11 ovf_b untouched", ovf_b, 1'b0);

    finish_run();
  end
endmodule